// File: doc/BRIEF.md
# Four-Channel Triggered DMA Controller

This block moves data between locations on a shared memory bus on behalf of four independent channels. Each channel holds a start address for reading, a start address for writing, a unit count and a control word. When software turns a channel on, the block latches working copies of the addresses and the count. The channel then either starts at once or waits for a horizontal-blank or vertical-blank pulse. Each unit is one read followed by one write on a single request/grant master port, in 16-bit or 32-bit size.

After each unit, the read and write addresses move independently. Each can go up, go down or stay fixed. A fourth mode goes up during a run and returns the write address to its programmed start when a repeating channel runs again. A channel that does not repeat turns itself off when it finishes. A repeating channel reloads its count and waits for its next trigger. Each channel can signal the end of a run on its own interrupt line. Only one channel owns the bus at a time. The lowest-numbered channel that has work wins at every unit boundary.

Software writes registers through a simple write strobe with a channel number and a register selector. The enable bit of every channel is visible on an output.

Top module: `quad_dma_engine`

## Requirements
- R1: After reset, `mem_req`, `chan_en` and `irq` are all zero.
- R2: Each unit is a read at the working read address (`mem_we`=0) and then a write (`mem_we`=1) at the working write address of the data returned by that read. A request is held until `mem_gnt`.
- R3: Control bits [3:2] set the read-address mode and bits [1:0] set the write-address mode: 0 goes up, 1 goes down, 2 stays fixed, 3 goes up. The step is 2 bytes, or 4 bytes when control bit 5 (wide) is set, and `mem_wide` follows that bit.
- R4: A count of zero runs 2^(CW-2) units on channels 0 to 2 and 2^CW units on the last channel. The default CW=16 gives 0x4000 and 0x10000.
- R5: Writes to the address registers (selector 0 = read address, 1 = write address) clear bit 0. A wide channel latches both addresses with bits [1:0] cleared. Selector 2 is the count and selector 3 is the control word.
- R6: Only a 0-to-1 change of control bit 15 (enable) latches the working addresses and count. Rewriting the control word while enabled leaves them untouched.
- R7: Control bits [7:6] select the start: 0 starts at once, 1 waits for `vblank_i`, 2 waits for `hblank_i`. A pulse of the other kind is ignored, and value 3 never starts a transfer.
- R8: When a blank pulse triggers several channels, the lower-numbered channel finishes all its units before the next one begins.
- R9: A lower-numbered channel that becomes pending during another channel's run takes the bus at the next unit boundary. The interrupted channel resumes afterwards with its addresses intact.
- R10: A channel without repeat (control bit 4 clear) clears its `chan_en` bit when its last unit completes.
- R11: A repeating channel stays enabled and reloads its count. On its next run, the read address continues from where it stopped, and the write address restarts only in write mode 3.
- R12: With control bit 8 set, `irq[ch]` is high for exactly one cycle, the cycle after the grant of the last write of a run. With bit 8 clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_reg | input | 2 | Register selector: 0 read addr, 1 write addr, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| hblank_i | input | 1 | Horizontal-blank trigger pulse |
| vblank_i | input | 1 | Vertical-blank trigger pulse |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wide | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; for a read, marks `mem_rdata` valid |
| mem_rdata | input | 32 | Read data |
| chan_en | output | 4 | Enable bit of each channel |
| irq | output | 4 | Per-channel completion pulse |

## Verification
A wrong working address shows up at `mem_addr` on the next unit of the affected channel. The first divergence can appear as early as the read of the second unit, and at the latest on the first unit of the next repeat run, where reload errors surface. A wrong remaining count shows up as an early or late interrupt pulse and `chan_en` drop, observed against the number of write grants. A wrong arbitration choice shows up as a foreign address in the middle of a run, within one unit of the trigger.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int QD_AW = 32;
  localparam int CTL_W = 16;

  typedef enum logic [1:0] {AM_UP = 2'd0, AM_DOWN = 2'd1, AM_HOLD = 2'd2, AM_UP_RLD = 2'd3} addr_mode_e;
  typedef enum logic [1:0] {ST_NOW = 2'd0, ST_VBL = 2'd1, ST_HBL = 2'd2, ST_SPECIAL = 2'd3} start_e;
  typedef enum logic [1:0] {SEL_RADDR = 2'd0, SEL_WADDR = 2'd1, SEL_COUNT = 2'd2, SEL_CTRL = 2'd3} reg_sel_e;

  typedef struct packed {
    logic       en;
    logic [4:0] rsvd;
    logic       xreq;
    logic       irq_en;
    start_e     start;
    logic       wide;
    logic       rpt;
    addr_mode_e rmode;
    addr_mode_e wmode;
  } ctrl_t;

  // Step an address by one unit according to its mode.
  function automatic logic [QD_AW-1:0] step_addr(logic [QD_AW-1:0] a, addr_mode_e m, logic wide);
    logic [QD_AW-1:0] st;
    st = wide ? QD_AW'(4) : QD_AW'(2);
    case (m)
      AM_DOWN: return a - st;
      AM_HOLD: return a;
      default: return a + st;
    endcase
  endfunction

  // Force alignment to the unit size.
  function automatic logic [QD_AW-1:0] align_addr(logic [QD_AW-1:0] a, logic wide);
    return wide ? {a[QD_AW-1:2], 2'b00} : {a[QD_AW-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/qdma_arbiter.sv
module qdma_arbiter #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = NCH'(1) << i;
    end
  end
endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
  import qdma_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int NCH    = 4,
  parameter int CW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [QD_AW-1:0] wr_data,
  input  logic             hblank,
  input  logic             vblank,
  input  logic             unit_done,
  output logic             pending,
  output logic             enabled,
  output logic             wide,
  output logic [QD_AW-1:0] cur_raddr,
  output logic [QD_AW-1:0] cur_waddr,
  output logic             irq
);
  localparam int LW      = CW + 1;
  localparam int MAX_CNT = (CH_IDX == NCH - 1) ? (1 << CW) : (1 << (CW - 2));

  ctrl_t            ctl_q;
  logic [QD_AW-1:0] raddr_q, waddr_q, wr_r_q, wr_w_q;
  logic [CW-1:0]    cnt_q;
  logic [LW-1:0]    left_q;
  logic             pend_q, irq_q;

  function automatic logic [LW-1:0] load_count(logic [CW-1:0] c);
    return (c == '0) ? LW'(MAX_CNT) : LW'(c);
  endfunction

  ctrl_t ctl_new;
  logic  ctl_wr, arm, last_unit, blank_hit;
  assign ctl_new   = ctrl_t'(wr_data[CTL_W-1:0]);
  assign ctl_wr    = wr_en && (wr_sel == SEL_CTRL);
  assign arm       = ctl_wr && !ctl_q.en && ctl_new.en;
  assign last_unit = unit_done && ctl_q.en && (left_q == LW'(1));
  assign blank_hit = ctl_q.en && !(last_unit && !ctl_q.rpt) &&
                     ((hblank && ctl_q.start == ST_HBL) || (vblank && ctl_q.start == ST_VBL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      raddr_q <= '0;
      waddr_q <= '0;
      cnt_q   <= '0;
      wr_r_q  <= '0;
      wr_w_q  <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (unit_done && ctl_q.en) begin
        wr_r_q <= step_addr(wr_r_q, ctl_q.rmode, ctl_q.wide);
        wr_w_q <= step_addr(wr_w_q, ctl_q.wmode, ctl_q.wide);
        left_q <= left_q - LW'(1);
        if (last_unit) begin
          pend_q <= 1'b0;
          irq_q  <= ctl_q.irq_en;
          if (ctl_q.rpt) begin
            left_q <= load_count(cnt_q);
            if (ctl_q.wmode == AM_UP_RLD) wr_w_q <= align_addr(waddr_q, ctl_q.wide);
          end else begin
            ctl_q.en <= 1'b0;
          end
        end
      end
      if (blank_hit) pend_q <= 1'b1;
      if (wr_en) begin
        case (wr_sel)
          SEL_RADDR: raddr_q <= {wr_data[QD_AW-1:1], 1'b0};
          SEL_WADDR: waddr_q <= {wr_data[QD_AW-1:1], 1'b0};
          SEL_COUNT: cnt_q   <= wr_data[CW-1:0];
          default: begin
            ctl_q <= ctl_new;
            if (arm) begin
              wr_r_q <= align_addr(raddr_q, ctl_new.wide);
              wr_w_q <= align_addr(waddr_q, ctl_new.wide);
              left_q <= load_count(cnt_q);
              pend_q <= (ctl_new.start == ST_NOW);
            end else if (!ctl_new.en) begin
              pend_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  logic unused_ctl_bits;
  assign unused_ctl_bits = &{1'b0, ctl_q.rsvd, ctl_q.xreq};

  assign pending   = pend_q && ctl_q.en;
  assign enabled   = ctl_q.en;
  assign wide      = ctl_q.wide;
  assign cur_raddr = wr_r_q;
  assign cur_waddr = wr_w_q;
  assign irq       = irq_q;
endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
  import qdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             pend,
  input  logic [NCH-1:0]             wide_vec,
  input  logic [NCH-1:0][QD_AW-1:0]  raddr_vec,
  input  logic [NCH-1:0][QD_AW-1:0]  waddr_vec,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic                       mem_wide,
  output logic [QD_AW-1:0]           mem_addr,
  output logic [DW-1:0]              mem_wdata,
  input  logic                       mem_gnt,
  input  logic [DW-1:0]              mem_rdata,
  output logic [NCH-1:0]             unit_done
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

  mv_state_e      state_q;
  logic [NCH-1:0] owner_q, pick;
  logic [DW-1:0]  data_q;
  logic [IW-1:0]  own_idx;

  function automatic logic [IW-1:0] oh_to_idx(logic [NCH-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++) if (oh[i]) r = IW'(i);
    return r;
  endfunction

  qdma_arbiter #(.NCH(NCH)) u_arb (.pend(pend), .pick(pick));

  assign own_idx = oh_to_idx(owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      owner_q <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (pick != '0) begin
          owner_q <= pick;
          state_q <= MV_READ;
        end
        MV_READ: if (mem_gnt) begin
          data_q  <= mem_rdata;
          state_q <= MV_WRITE;
        end
        default: if (mem_gnt) state_q <= MV_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q != MV_IDLE);
  assign mem_we    = (state_q == MV_WRITE);
  assign mem_wide  = wide_vec[own_idx];
  assign mem_addr  = (state_q == MV_WRITE) ? waddr_vec[own_idx] : raddr_vec[own_idx];
  assign mem_wdata = data_q;
  assign unit_done = (state_q == MV_WRITE && mem_gnt) ? owner_q : '0;
endmodule

// File: rtl/quad_dma_engine.sv
module quad_dma_engine
  import qdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int DW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [1:0]       cfg_reg,
  input  logic [QD_AW-1:0] cfg_wdata,
  input  logic             hblank_i,
  input  logic             vblank_i,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [QD_AW-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic [NCH-1:0]   chan_en,
  output logic [NCH-1:0]   irq
);
  logic [NCH-1:0]            pend_vec, wide_vec, unit_done;
  logic [NCH-1:0][QD_AW-1:0] raddr_vec, waddr_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qdma_channel #(.CH_IDX(g), .NCH(NCH), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_ch == CHW'(g))),
      .wr_sel   (reg_sel_e'(cfg_reg)),
      .wr_data  (cfg_wdata),
      .hblank   (hblank_i),
      .vblank   (vblank_i),
      .unit_done(unit_done[g]),
      .pending  (pend_vec[g]),
      .enabled  (chan_en[g]),
      .wide     (wide_vec[g]),
      .cur_raddr(raddr_vec[g]),
      .cur_waddr(waddr_vec[g]),
      .irq      (irq[g])
    );
  end

  qdma_mover #(.NCH(NCH), .DW(DW)) u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_vec),
    .wide_vec (wide_vec),
    .raddr_vec(raddr_vec),
    .waddr_vec(waddr_vec),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_wide (mem_wide),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_gnt  (mem_gnt),
    .mem_rdata(mem_rdata),
    .unit_done(unit_done)
  );
endmodule

// File: rtl/qdma_checker.sv
module qdma_checker #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_wide,
  input logic           mem_gnt,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] unit_done
);
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we));

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we)));

  a_r5_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wide) |-> (mem_addr[1:0] == 2'b00));

  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |=> ((irq & $past(irq)) == '0));

  a_r12_irq_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ((irq & ~$past(unit_done)) == '0));
endmodule

bind quad_dma_engine qdma_checker #(.NCH(NCH), .AW(qdma_pkg::QD_AW)) u_qdma_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wide (mem_wide),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .irq      (irq),
  .unit_done(unit_done)
);

// File: tb/quad_dma_engine_test.sv
module quad_dma_engine_test;
  localparam int NCH = 4;
  localparam int CW  = 10;
  localparam int LAT = 1;
  localparam int LOGN = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cfg_we, hblank_i, vblank_i;
  logic [1:0]  cfg_ch, cfg_reg;
  logic [31:0] cfg_wdata;
  logic        mem_req, mem_we, mem_wide, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  chan_en, irq;

  quad_dma_engine #(.NCH(NCH), .CW(CW)) uut (.*);

  int errors = 0, checks = 0;
  logic [31:0] rd_log [LOGN];
  logic [31:0] wa_log [LOGN];
  logic [31:0] wd_log [LOGN];
  int rd_n, wr_n, lat_cnt;
  int irq_n [4];

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  // control word: [15] en, [8] irq, [7:6] start, [5] wide, [4] repeat, [3:2] read mode, [1:0] write mode
  function automatic logic [31:0] mk_ctl(bit en, bit ie, int st, bit wd, bit rp, int rm, int wm);
    return {16'h0, en, 6'b0, ie, 2'(st), wd, rp, 2'(rm), 2'(wm)};
  endfunction

  // behavioural memory with fixed latency; logs every granted access
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rdata = '0; lat_cnt = 0;
    end else if (mem_req && !mem_gnt && lat_cnt == LAT) begin
      mem_gnt = 1'b1; mem_rdata = pat(mem_addr); lat_cnt = 0;
      if (mem_we) begin
        if (wr_n < LOGN) begin wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; end
        wr_n++;
      end else begin
        if (rd_n < LOGN) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end else begin
      mem_gnt = 1'b0;
      if (mem_req) lat_cnt++;
    end
    for (int i = 0; i < 4; i++) if (irq[i]) irq_n[i]++;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0;
    for (int i = 0; i < 4; i++) irq_n[i] = 0;
  endtask

  task automatic wreg(int ch, int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_reg = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(int ch, logic [31:0] ra, logic [31:0] wa, int cnt);
    wreg(ch, 0, ra); wreg(ch, 1, wa); wreg(ch, 2, 32'(cnt));
  endtask

  task automatic pulse(bit h);
    @(negedge clk);
    if (h) hblank_i = 1'b1; else vblank_i = 1'b1;
    @(negedge clk);
    hblank_i = 1'b0; vblank_i = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
    end
  endtask

  task automatic t_reset();
    check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    check(chan_en == 4'h0, "R1", "chan_en", chan_en, 0);
    check(irq == 4'h0, "R1", "irq", irq, 0);
  endtask

  task automatic t_immediate_half();
    bit ok = 1;
    clear_logs();
    setup(1, 32'h100, 32'h201, 4);
    wreg(1, 3, mk_ctl(1, 1, 0, 0, 0, 0, 0));
    wait_quiet();
    check(rd_n == 4 && wr_n == 4, "R2", "unit count", wr_n, 4);
    for (int i = 0; i < 4; i++) begin
      if (rd_log[i] != 32'h100 + 32'(2 * i)) ok = 0;
      if (wa_log[i] != 32'h200 + 32'(2 * i)) ok = 0;
      if (wd_log[i] != pat(rd_log[i])) ok = 0;
    end
    check(ok, "R2", "read/write sequence and data", wa_log[3], 32'h206);
    check(wa_log[0] == 32'h200, "R5", "bit0 dropped", wa_log[0], 32'h200);
    check(chan_en[1] == 1'b0, "R10", "enable cleared", chan_en[1], 0);
    check(irq_n[1] == 1, "R12", "irq pulse count", irq_n[1], 1);
  endtask

  task automatic t_wide_modes();
    clear_logs();
    setup(2, 32'h303, 32'h406, 3);
    wreg(2, 3, mk_ctl(1, 0, 0, 1, 0, 1, 2));
    wait_quiet();
    check(rd_log[0] == 32'h300, "R5", "wide read align", rd_log[0], 32'h300);
    check(rd_log[2] == 32'h2F8, "R3", "decrement by 4", rd_log[2], 32'h2F8);
    check(wa_log[0] == 32'h404 && wa_log[2] == 32'h404, "R3", "fixed write addr", wa_log[2], 32'h404);
    check(irq_n[2] == 0, "R12", "no irq when disabled", irq_n[2], 0);
  endtask

  task automatic t_vblank_reload();
    clear_logs();
    setup(0, 32'h1000, 32'h2000, 2);
    wreg(0, 3, mk_ctl(1, 1, 1, 0, 1, 0, 3));
    repeat (10) @(negedge clk);
    check(rd_n == 0, "R7", "waits for vblank", rd_n, 0);
    pulse(1);
    wait_quiet();
    check(rd_n == 0, "R7", "hblank ignored", rd_n, 0);
    pulse(0);
    wait_quiet();
    check(wr_n == 2 && wa_log[1] == 32'h2002, "R7", "vblank run", wa_log[1], 32'h2002);
    check(chan_en[0] == 1'b1, "R11", "repeat stays enabled", chan_en[0], 1);
    pulse(0);
    wait_quiet();
    check(rd_log[2] == 32'h1004, "R11", "read addr continues", rd_log[2], 32'h1004);
    check(wa_log[2] == 32'h2000, "R11", "write addr reload mode 3", wa_log[2], 32'h2000);
    check(wr_n == 4, "R11", "count reloaded", wr_n, 4);
    wreg(0, 3, 32'h0);
  endtask

  task automatic t_hblank_norelatch();
    clear_logs();
    setup(3, 32'h1000, 32'h3000, 1);
    wreg(3, 3, mk_ctl(1, 0, 2, 0, 1, 0, 0));
    pulse(1);
    wait_quiet();
    wreg(3, 0, 32'h5000);
    wreg(3, 3, mk_ctl(1, 0, 2, 0, 1, 0, 0));
    pulse(1);
    wait_quiet();
    check(rd_log[1] == 32'h1002, "R6", "no relatch while enabled", rd_log[1], 32'h1002);
    check(wa_log[1] == 32'h3002, "R11", "no write reload in mode 0", wa_log[1], 32'h3002);
    wreg(3, 3, 32'h0);
  endtask

  task automatic t_blank_order();
    clear_logs();
    setup(2, 32'h800, 32'h900, 2);
    wreg(2, 3, mk_ctl(1, 0, 2, 0, 0, 0, 0));
    setup(1, 32'h100, 32'h180, 2);
    wreg(1, 3, mk_ctl(1, 0, 2, 0, 0, 0, 0));
    pulse(1);
    wait_quiet();
    check(rd_log[0] == 32'h100 && rd_log[1] == 32'h102 && rd_log[2] == 32'h800 && rd_log[3] == 32'h802,
          "R8", "channel order", rd_log[2], 32'h800);
  endtask

  task automatic t_preempt();
    int k = -1, j = 0;
    bit ok = 1;
    clear_logs();
    setup(3, 32'hA00, 32'hD00, 8);
    wreg(3, 3, mk_ctl(1, 0, 0, 0, 0, 0, 0));
    while (wr_n < 2) @(negedge clk);
    setup(0, 32'hB00, 32'hC00, 1);
    wreg(0, 3, mk_ctl(1, 0, 0, 0, 0, 0, 0));
    wait_quiet();
    for (int i = 0; i < rd_n && i < LOGN; i++) begin
      if (rd_log[i] == 32'hB00) k = i;
      else begin
        if (rd_log[i] != 32'hA00 + 32'(2 * j)) ok = 0;
        j++;
      end
    end
    check(k > 0 && k < 8, "R9", "preempt position", k, 4);
    check(ok && rd_n == 9, "R9", "interrupted run intact", rd_n, 9);
  endtask

  task automatic t_zero_count();
    clear_logs();
    setup(0, 32'h0, 32'h8000, 0);
    wreg(0, 3, mk_ctl(1, 0, 0, 0, 0, 0, 0));
    wait_quiet();
    check(wr_n == (1 << (CW - 2)), "R4", "zero count low channel", wr_n, 1 << (CW - 2));
    clear_logs();
    setup(3, 32'h0, 32'h8000, 0);
    wreg(3, 3, mk_ctl(1, 0, 0, 0, 0, 0, 0));
    wait_quiet();
    check(wr_n == (1 << CW), "R4", "zero count last channel", wr_n, 1 << CW);
    check(wa_log[(1 << CW) - 1] == 32'h8000 + 32'(2 * ((1 << CW) - 1)), "R4", "last write addr",
          wa_log[(1 << CW) - 1], 32'h8000 + 32'(2 * ((1 << CW) - 1)));
  endtask

  task automatic t_special_start();
    clear_logs();
    setup(0, 32'h100, 32'h200, 1);
    wreg(0, 3, mk_ctl(1, 1, 3, 0, 0, 0, 0));
    pulse(1);
    pulse(0);
    wait_quiet();
    check(rd_n == 0 && irq_n[0] == 0, "R7", "start value 3 never runs", rd_n, 0);
    wreg(0, 3, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_reg = '0; cfg_wdata = '0;
    hblank_i = 1'b0; vblank_i = 1'b0;
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_immediate_half();
    t_wide_modes();
    t_vblank_reload();
    t_hblank_norelatch();
    t_blank_order();
    t_preempt();
    t_zero_count();
    t_special_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule